// File: doc/BRIEF.md
# Address-Decoded Wait-State Generator

This block produces the ready input of a single-clock 8-bit CPU core. It lets a fast core clock reach slow external devices. It watches the core's address bus and its access-valid indication, and decodes one chip select per address region. Each region has its own wait count, fixed by parameter. When an access hits a region whose count is non-zero, the block pulls ready low at once. A down-counter loaded with that count keeps ready low. When the counter reaches zero, ready goes high for the one cycle in which the access completes.

Stalls are always a whole number of core clock cycles. All state sits in the core clock domain. Ready depends only on that state and on the core's address and valid outputs, which are themselves registered. Accesses to fast regions, and to addresses no region claims, never see ready low. The first cycle after a completed access is treated as the first cycle of a new access, so repeated slow accesses form a fixed period.

Default map:

| Region | Address range | Wait count |
|--------|---------------|------------|
| 0 | 0x0000–0x3FFF | 0 |
| 1 | 0x8000–0xBFFF | 1 |
| 2 | 0xC000–0xDFFF | 3 |
| 3 | 0x8000–0xFFFF | 7 |

- Region 3 has the lowest priority, so in practice it claims 0xE000–0xFFFF.
- No region claims 0x4000–0x7FFF.

Top module: `ws_wait_gen`

## Requirements
- R1: After reset, with `acc_valid` low, `rdy` is 1 and `cs` is 0. The first slow access after reset stalls for its full wait count.
- R2: With `acc_valid` high, at most one `cs` bit is set. Bit i is set for the lowest-index region i whose `(addr & MASK[i]) == BASE[i]`; for example, 0xA000 selects region 1 (`cs` = 4'b0010) and not region 3.
- R3: An access to a region with wait count 0 sees `rdy` high in its first cycle (for example, 0x1234 gives `cs` = 4'b0001).
- R4: An access to a region with wait count W > 0 sees `rdy` low for exactly W consecutive cycles, starting in its first cycle, and then high for one cycle. The defaults give 1, 3 and 7 low cycles for regions 1, 2 and 3.
- R5: A continuous stream of accesses to region 3 gives `rdy` high one cycle in eight. A stream to region 2 gives `rdy` high one cycle in four.
- R6: In back-to-back accesses to different regions, each access loads the wait count of its own region. No count carries over from the previous access.
- R7: While `acc_valid` is low, `rdy` is 1 and `cs` is 0. Dropping `acc_valid` during a stall abandons it, and the next slow access stalls for its full count.
- R8: A valid access that hits no region gives `cs` = 0 and `rdy` high (for example, 0x5000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Core is performing a bus access this cycle |
| addr | input | ADDR_W | Core address bus |
| cs | output | N_REG | One-hot chip selects, bit i for region i |
| rdy | output | 1 | Ready to the core; low stalls the current access |

## Verification
The assertions assume that the core holds `addr` steady for as long as `rdy` is low, as a stalled core does, unless it drops `acc_valid`. They also assume that `acc_valid` is low throughout reset. The stimulus drives new addresses only in the cycle after a sampled high `rdy`, or after `acc_valid` has been taken low. Reset is applied with `acc_valid` low. The abandon scenario changes nothing but `acc_valid` in the middle of a stall.

// File: rtl/ws_pkg.sv
`timescale 1ns/1ps
package ws_pkg;

   typedef enum logic {
      WS_IDLE  = 1'b0,
      WS_STALL = 1'b1
   } ws_state_e;

endpackage

// File: rtl/ws_region_decode.sv
`timescale 1ns/1ps
module ws_region_decode #(
   parameter int ADDR_W = 16,
   parameter int N_REG  = 4,
   parameter int CNT_W  = 4,
   parameter logic [N_REG-1:0][ADDR_W-1:0] REG_BASE = '0,
   parameter logic [N_REG-1:0][ADDR_W-1:0] REG_MASK = '0,
   parameter logic [N_REG-1:0][CNT_W-1:0]  REG_WAIT = '0
) (
   input  logic              valid,
   input  logic [ADDR_W-1:0] addr,
   output logic [N_REG-1:0]  cs,
   output logic [CNT_W-1:0]  wait_sel
);

   logic [N_REG-1:0] hit;

   generate
      for (genvar i = 0; i < N_REG; i++) begin : g_match
         if ((REG_BASE[i] & ~REG_MASK[i]) != '0) begin : g_bad_base
            $error("region base has bits outside its mask");
         end
         assign hit[i] = valid && ((addr & REG_MASK[i]) == REG_BASE[i]);
      end
   endgenerate

   // Lowest index wins: scan from the top so lower indices overwrite.
   always_comb begin
      cs       = '0;
      wait_sel = '0;
      for (int i = N_REG - 1; i >= 0; i--) begin
         if (hit[i]) begin
            cs       = '0;
            cs[i]    = 1'b1;
            wait_sel = REG_WAIT[i];
         end
      end
   end

endmodule

// File: rtl/ws_wait_counter.sv
`timescale 1ns/1ps
module ws_wait_counter #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid,
   input  logic [CNT_W-1:0] load_wait,
   output logic             rdy
);
   import ws_pkg::*;

   localparam logic [CNT_W-1:0] CNT_ZERO = '0;
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   ws_state_e        state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             cnt_done;

   assign cnt_done = (cnt_q == CNT_ZERO);

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      rdy     = 1'b1;
      if (!valid) begin
         state_d = WS_IDLE;
         cnt_d   = CNT_ZERO;
      end else if (state_q == WS_STALL) begin
         rdy = cnt_done;
         if (cnt_done) begin
            state_d = WS_IDLE;
         end else begin
            cnt_d = cnt_q - CNT_ONE;
         end
      end else if (load_wait != CNT_ZERO) begin
         rdy     = 1'b0;
         state_d = WS_STALL;
         cnt_d   = load_wait - CNT_ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= WS_IDLE;
         cnt_q   <= CNT_ZERO;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

endmodule

// File: rtl/ws_wait_gen.sv
`timescale 1ns/1ps
module ws_wait_gen #(
   parameter int ADDR_W = 16,
   parameter int N_REG  = 4,
   parameter int CNT_W  = 4,
   parameter logic [N_REG-1:0][ADDR_W-1:0] REG_BASE =
      {16'h8000, 16'hC000, 16'h8000, 16'h0000},
   parameter logic [N_REG-1:0][ADDR_W-1:0] REG_MASK =
      {16'h8000, 16'hE000, 16'hC000, 16'hC000},
   parameter logic [N_REG-1:0][CNT_W-1:0]  REG_WAIT =
      {4'd7, 4'd3, 4'd1, 4'd0}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] addr,
   output logic [N_REG-1:0]  cs,
   output logic              rdy
);

   generate
      if (ADDR_W < 1 || N_REG < 1 || CNT_W < 1) begin : g_bad_params
         $error("ADDR_W, N_REG and CNT_W must all be positive");
      end
   endgenerate

   logic [CNT_W-1:0] wait_sel;

   ws_region_decode #(
      .ADDR_W  (ADDR_W),
      .N_REG   (N_REG),
      .CNT_W   (CNT_W),
      .REG_BASE(REG_BASE),
      .REG_MASK(REG_MASK),
      .REG_WAIT(REG_WAIT)
   ) u_decode (
      .valid   (acc_valid),
      .addr    (addr),
      .cs      (cs),
      .wait_sel(wait_sel)
   );

   ws_wait_counter #(
      .CNT_W(CNT_W)
   ) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (acc_valid),
      .load_wait(wait_sel),
      .rdy      (rdy)
   );

endmodule

// File: rtl/ws_wait_gen_chk.sv
`timescale 1ns/1ps
module ws_wait_gen_chk #(
   parameter int ADDR_W = 16,
   parameter int N_REG  = 4,
   parameter int CNT_W  = 4,
   parameter logic [N_REG-1:0][CNT_W-1:0] REG_WAIT = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic [ADDR_W-1:0] addr,
   input logic [N_REG-1:0]  cs,
   input logic              rdy
);

   localparam int RUN_W = CNT_W + 1;
   localparam logic [RUN_W-1:0] RUN_MAX = '1;

   logic [CNT_W-1:0] wait_of_cs;
   logic [RUN_W-1:0] low_run;

   always_comb begin
      wait_of_cs = '0;
      for (int i = 0; i < N_REG; i++) begin
         if (cs[i]) wait_of_cs = wait_of_cs | REG_WAIT[i];
      end
   end

   // Number of consecutive low-ready cycles seen before this one.
   always_ff @(posedge clk) begin
      if (!rst_n || !acc_valid || rdy) low_run <= '0;
      else if (low_run != RUN_MAX)     low_run <= low_run + 1'b1;
   end

   assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs));

   assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (rdy && cs == '0));

   assert_no_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && cs == '0) |-> rdy);

   assert_fast_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && low_run == '0 && wait_of_cs == '0) |-> rdy);

   assert_first_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && low_run == '0 && wait_of_cs != '0) |-> !rdy);

   assert_low_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && rdy && low_run != '0) |-> (low_run == {1'b0, wait_of_cs}));

   assert_addr_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !rdy) |=> (!acc_valid || $stable(addr)));

endmodule

bind ws_wait_gen ws_wait_gen_chk #(
   .ADDR_W  (ADDR_W),
   .N_REG   (N_REG),
   .CNT_W   (CNT_W),
   .REG_WAIT(REG_WAIT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .acc_valid(acc_valid),
   .addr     (addr),
   .cs       (cs),
   .rdy      (rdy)
);

// File: tb/tb_ws_wait_gen.sv
`timescale 1ns/1ps
module tb_ws_wait_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [15:0] addr = 16'h0000;
   logic [3:0]  cs;
   logic        rdy;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   ws_wait_gen dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_valid(acc_valid),
      .addr     (addr),
      .cs       (cs),
      .rdy      (rdy)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // One access: drive at negedge, count low-ready cycles until ready.
   task automatic do_access(input logic [15:0] a, input logic [3:0] exp_cs,
                            input int exp_lows, input string tag);
      int lows = 0;
      @(negedge clk);
      acc_valid = 1'b1;
      addr = a;
      #1;
      check(cs == exp_cs, {tag, " cs"}, int'(cs), int'(exp_cs));
      while (!rdy && lows < 20) begin
         @(negedge clk);
         #1;
         lows++;
      end
      check(lows == exp_lows, {tag, " low cycles"}, lows, exp_lows);
   endtask

   task automatic go_idle();
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      acc_valid = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      check(rdy == 1'b1, "R1 rdy in reset", int'(rdy), 1);
      check(cs == 4'b0000, "R1 cs in reset", int'(cs), 0);
      @(negedge clk);
      rst_n = 1'b1;
      do_access(16'hE000, 4'b1000, 7, "R1 first slow access after reset");
      go_idle();
      #1;
      check(rdy == 1'b1 && cs == 4'b0000, "R7 idle", int'({cs, rdy}), 1);
   endtask

   task automatic t_regions();
      do_access(16'h1234, 4'b0001, 0, "R3 fast region");
      do_access(16'h9000, 4'b0010, 1, "R4 region1");
      do_access(16'hC800, 4'b0100, 3, "R4 region2");
      do_access(16'hF000, 4'b1000, 7, "R4 region3");
      do_access(16'hA000, 4'b0010, 1, "R2 priority overlap");
      do_access(16'h5000, 4'b0000, 0, "R8 unmapped");
      go_idle();
   endtask

   task automatic t_back_to_back();
      do_access(16'hF000, 4'b1000, 7, "R6 b2b region3");
      do_access(16'h1000, 4'b0001, 0, "R6 b2b region0");
      do_access(16'hC000, 4'b0100, 3, "R6 b2b region2");
      do_access(16'h9000, 4'b0010, 1, "R6 b2b region1");
      do_access(16'h4000, 4'b0000, 0, "R6 b2b unmapped");
      do_access(16'hFFFF, 4'b1000, 7, "R6 b2b region3 again");
      go_idle();
   endtask

   task automatic t_periodic(input logic [15:0] a, input int period, input string tag);
      int highs = 0;
      int bad = 0;
      @(negedge clk);
      acc_valid = 1'b1;
      addr = a;
      for (int c = 0; c < 3 * period; c++) begin
         #1;
         if (rdy) highs++;
         if (rdy != ((c % period) == period - 1)) bad++;
         @(negedge clk);
      end
      acc_valid = 1'b0;
      check(highs == 3, {tag, " high count"}, highs, 3);
      check(bad == 0, {tag, " pattern mismatches"}, bad, 0);
   endtask

   task automatic t_abort();
      @(negedge clk);
      acc_valid = 1'b1;
      addr = 16'hE800;
      #1;
      check(rdy == 1'b0, "R7 stall started", int'(rdy), 0);
      repeat (2) @(negedge clk);
      acc_valid = 1'b0;
      #1;
      check(rdy == 1'b1 && cs == 4'b0000, "R7 abandon releases", int'({cs, rdy}), 1);
      do_access(16'hE800, 4'b1000, 7, "R7 full count after abandon");
      go_idle();
   endtask

   initial begin
      t_reset();
      t_regions();
      t_back_to_back();
      t_periodic(16'hE000, 8, "R5 one in eight");
      t_periodic(16'hC000, 4, "R5 one in four");
      t_abort();
      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule